// File: doc/BRIEF.md
# Cascaded System and Peripheral Clock Prescaler

This block turns one source clock into a set of single-cycle enable strobes for the clock domains of a chip. A first stage divides the source rate by 1, 2, 4, 8 or 16 and produces the system tick. A second stage of parallel dividers counts those system ticks, not source cycles, and divides them again by 1, 2, 4 or 8. Each of these dividers drives one peripheral-group tick. Logic in each domain runs on the source clock and advances only in cycles where its tick is high.

A third path builds a toggling clock for an external pin, also counted in system ticks, through its own prescaler. The pin is held low after reset until software enables it. Its ratio resets to 4. When the system stage runs at full speed and the pin ratio is below 4, a configuration-error flag is raised.

Every divide field has its own write strobe. A new value takes effect only when the affected counter completes a period, so a period already in progress is never cut short.

Top module: `clk_prescale_tree`

## Requirements
- R1: After reset all divide codes are 0 and the pin ratio code is 2. So in the first cycle after reset `sys_tick_o` and every `per_tick_o` bit are high, and `cko_o` and `cko_cfg_err_o` are low.
- R2: System divide code c in 0..4 gives a `sys_tick_o` that is high for one cycle every 2^c source cycles.
- R3: System divide codes 5, 6 and 7 are reserved and give a period of 16 source cycles.
- R4: Peripheral code p in 0..3, held in bits [2g+1:2g] of `per_div_i` for group g, makes `per_tick_o[g]` pulse once every 2^p system ticks. It is high only in cycles where `sys_tick_o` is high.
- R5: A written divide code takes effect at the first period end at or after the write cycle. If a system divider with period 8 is set to code 0 one cycle after a tick, its next tick still comes 8 cycles after the last one, and ticks come every cycle after that.
- R6: `cko_o` stays low while the output enable is clear. After the enable is cleared, `cko_o` is low from the next cycle on.
- R7: Pin ratio code k in 1..3 gives a ratio of 2^k. `cko_o` is then high for 2^(k-1) system ticks and low for 2^(k-1) system ticks, and it changes level only in the cycle after a system tick.
- R8: Pin ratio code 0 (ratio 1) makes `cko_o` equal to `sys_tick_o` delayed by one cycle.
- R9: If the output is enabled with no pin ratio written since reset, the pin ratio is 4: with a system period of 2 cycles, `cko_o` is high for 4 cycles and low for 4.
- R10: `cko_cfg_err_o` is high exactly when the output is enabled, the system code is 0 and the pin ratio code is 0 or 1. It changes in the cycle after the write.
- R11: A pin ratio written while the output is enabled takes effect only after the current high phase ends. A change from code 3 to code 1 at full speed, written at the start of a high phase, gives a 4-cycle high phase and then a 1-cycle low phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Source clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sys_div_we_i | input | 1 | Write strobe for the system divide code |
| sys_div_i | input | 3 | System divide code |
| per_div_we_i | input | NUM_PERIPH | Write strobe per peripheral group |
| per_div_i | input | 2*NUM_PERIPH | Peripheral divide codes, 2 bits per group |
| cko_en_we_i | input | 1 | Write strobe for the output enable |
| cko_en_i | input | 1 | Output enable value |
| cko_div_we_i | input | 1 | Write strobe for the pin ratio code |
| cko_div_i | input | 2 | Pin ratio code |
| sys_tick_o | output | 1 | System-rate enable strobe |
| per_tick_o | output | NUM_PERIPH | Peripheral-group enable strobes |
| cko_o | output | 1 | Toggling clock for the external pin |
| cko_cfg_err_o | output | 1 | Full-speed pin ratio configuration error |

## Verification
The assertions take the write strobes to be synchronous single-cycle pulses with stable codes and a clean, asynchronously applied reset. They do not constrain code values: reserved system codes must also keep the counters in range. The bench keeps within this by changing inputs only on the falling clock edge and by holding each strobe for exactly one cycle. It draws system codes across the full 0..7 range, reserved values included, and pin codes from 1..3. It waits long enough after each change for every pending period to finish before it measures.

// File: rtl/ck_pkg.sv
package ck_pkg;
    localparam int SYS_CODE_W   = 3;
    localparam int SYS_MAX_LOG  = 4;
    localparam int PER_CODE_W   = 2;
    localparam int PER_MAX_LOG  = 3;
    localparam int CKO_CODE_W   = 2;
    localparam int CKO_RST_CODE = 2;
endpackage

// File: rtl/ck_tick_div.sv
module ck_tick_div #(
    parameter int CODE_W  = 3,
    parameter int MAX_LOG = 4
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              step_i,
    input  logic              we_i,
    input  logic [CODE_W-1:0] code_i,
    output logic [CODE_W-1:0] code_o,
    output logic              tick_o
);
    localparam int CNT_W = (MAX_LOG < 1) ? 1 : MAX_LOG;

    typedef struct packed {
        logic [CODE_W-1:0] code;
        logic [CNT_W-1:0]  lim;
        logic [CNT_W-1:0]  cnt;
    } div_st_t;

    div_st_t st_d, st_q;

    function automatic logic [CNT_W-1:0] lim_of(input logic [CODE_W-1:0] c);
        int l;
        l = (int'(c) > MAX_LOG) ? MAX_LOG : int'(c);
        return CNT_W'((1 << l) - 1);
    endfunction

    logic wrap;
    assign wrap   = (st_q.cnt == st_q.lim);
    assign tick_o = step_i & wrap;
    assign code_o = st_q.code;

    always_comb begin
        st_d = st_q;
        if (we_i) st_d.code = code_i;
        if (step_i) begin
            if (wrap) begin
                st_d.cnt = '0;
                st_d.lim = lim_of(st_d.code);
            end else begin
                st_d.cnt = st_q.cnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    // R5: the counter never runs past the loaded period end
    a_r5_cnt_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.cnt <= st_q.lim);
    // R2: every loaded period is a power of two
    a_r2_lim_pow2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((st_q.lim + CNT_W'(1)) & st_q.lim) == '0);
endmodule

// File: rtl/ck_out_gen.sv
module ck_out_gen #(
    parameter int CODE_W   = 2,
    parameter int RST_CODE = 2
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              step_i,
    input  logic              full_speed_i,
    input  logic              en_we_i,
    input  logic              en_i,
    input  logic              div_we_i,
    input  logic [CODE_W-1:0] div_i,
    output logic              cko_o,
    output logic              cfg_err_o
);
    localparam int MAX_LOG = (1 << CODE_W) - 1;
    localparam int HW      = (MAX_LOG - 1 < 1) ? 1 : MAX_LOG - 1;

    typedef struct packed {
        logic              en;
        logic [CODE_W-1:0] code;
        logic [CODE_W-1:0] act;
        logic [HW-1:0]     cnt;
        logic              cko;
    } out_st_t;

    out_st_t st_d, st_q;

    function automatic logic [HW-1:0] half_lim(input logic [CODE_W-1:0] a);
        if (a == '0) return '0;
        return HW'((1 << (int'(a) - 1)) - 1);
    endfunction

    logic [HW-1:0] lim_q;
    assign lim_q     = half_lim(st_q.act);
    assign cko_o     = st_q.cko;
    assign cfg_err_o = st_q.en & full_speed_i & (st_q.code < CODE_W'(2));

    always_comb begin
        st_d = st_q;
        if (en_we_i)  st_d.en   = en_i;
        if (div_we_i) st_d.code = div_i;
        if (!st_q.en) begin
            st_d.cko = 1'b0;
            st_d.cnt = '0;
            st_d.act = st_d.code;
        end else if (step_i) begin
            if (st_q.act == '0) begin
                st_d.cko = 1'b1;
                st_d.cnt = '0;
                st_d.act = st_d.code;
            end else if (st_q.cnt == lim_q) begin
                st_d.cnt = '0;
                st_d.cko = ~st_q.cko;
                if (st_q.cko) st_d.act = st_d.code;
            end else begin
                st_d.cnt = st_q.cnt + HW'(1);
            end
        end else if (st_q.act == '0) begin
            st_d.cko = 1'b0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q      <= '0;
            st_q.code <= CODE_W'(RST_CODE);
            st_q.act  <= CODE_W'(RST_CODE);
        end else begin
            st_q <= st_d;
        end
    end

    // R6: disabled output is driven low on the next cycle
    a_r6_off_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !st_q.en |=> !cko_o);
    // R7: phase counter stays within the half-period
    a_r7_cnt_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.cnt <= lim_q);
endmodule

// File: rtl/clk_prescale_tree.sv
module clk_prescale_tree
    import ck_pkg::*;
#(
    parameter int NUM_PERIPH = 3
) (
    input  logic                           clk_i,
    input  logic                           rst_ni,
    input  logic                           sys_div_we_i,
    input  logic [SYS_CODE_W-1:0]          sys_div_i,
    input  logic [NUM_PERIPH-1:0]          per_div_we_i,
    input  logic [PER_CODE_W*NUM_PERIPH-1:0] per_div_i,
    input  logic                           cko_en_we_i,
    input  logic                           cko_en_i,
    input  logic                           cko_div_we_i,
    input  logic [CKO_CODE_W-1:0]          cko_div_i,
    output logic                           sys_tick_o,
    output logic [NUM_PERIPH-1:0]          per_tick_o,
    output logic                           cko_o,
    output logic                           cko_cfg_err_o
);
    logic [SYS_CODE_W-1:0] sys_code;
    logic [PER_CODE_W-1:0] per_code [NUM_PERIPH];

    ck_tick_div #(.CODE_W(SYS_CODE_W), .MAX_LOG(SYS_MAX_LOG)) u_sys_div (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .step_i (1'b1),
        .we_i   (sys_div_we_i),
        .code_i (sys_div_i),
        .code_o (sys_code),
        .tick_o (sys_tick_o)
    );

    for (genvar g = 0; g < NUM_PERIPH; g++) begin : g_per
        ck_tick_div #(.CODE_W(PER_CODE_W), .MAX_LOG(PER_MAX_LOG)) u_per_div (
            .clk_i  (clk_i),
            .rst_ni (rst_ni),
            .step_i (sys_tick_o),
            .we_i   (per_div_we_i[g]),
            .code_i (per_div_i[PER_CODE_W*g +: PER_CODE_W]),
            .code_o (per_code[g]),
            .tick_o (per_tick_o[g])
        );

        // R4: a peripheral tick only comes with a system tick
        a_r4_per_under_sys: assert property (@(posedge clk_i) disable iff (!rst_ni)
            per_tick_o[g] |-> sys_tick_o);
        // R5: a group's pending code moves only on its own write
        a_r5_code_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
            !per_div_we_i[g] |=> $stable(per_code[g]));
    end

    ck_out_gen #(.CODE_W(CKO_CODE_W), .RST_CODE(CKO_RST_CODE)) u_out (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .step_i       (sys_tick_o),
        .full_speed_i (sys_code == '0),
        .en_we_i      (cko_en_we_i),
        .en_i         (cko_en_i),
        .div_we_i     (cko_div_we_i),
        .div_i        (cko_div_i),
        .cko_o        (cko_o),
        .cfg_err_o    (cko_cfg_err_o)
    );

    // R7: the pin only rises in the cycle after a system tick
    a_r7_rise_after_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(cko_o) |-> $past(sys_tick_o));
endmodule

// File: tb/clk_prescale_tree_tb.sv
module clk_prescale_tree_tb;
    localparam int CLK_P = 10;
    localparam int NP    = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sys_we = 1'b0;
    logic [2:0] sys_c = '0;
    logic [NP-1:0] per_we = '0;
    logic [2*NP-1:0] per_c = '0;
    logic en_we = 1'b0, en_v = 1'b0, ck_we = 1'b0;
    logic [1:0] ck_c = '0;
    logic sys_tick, cko, err;
    logic [NP-1:0] per_tick;
    int total = 0, bad = 0;
    bit done = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    clk_prescale_tree #(.NUM_PERIPH(NP)) u_dut (
        .clk_i(clk), .rst_ni(rst_n),
        .sys_div_we_i(sys_we), .sys_div_i(sys_c),
        .per_div_we_i(per_we), .per_div_i(per_c),
        .cko_en_we_i(en_we), .cko_en_i(en_v),
        .cko_div_we_i(ck_we), .cko_div_i(ck_c),
        .sys_tick_o(sys_tick), .per_tick_o(per_tick),
        .cko_o(cko), .cko_cfg_err_o(err)
    );

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int sys_period(input int c);
        return (c > 4) ? 16 : (1 << c);
    endfunction

    function automatic logic sig(input int idx);
        return (idx == 0) ? sys_tick : per_tick[idx-1];
    endfunction

    task automatic wr_sys(input logic [2:0] c);
        sys_we = 1'b1; sys_c = c; @(negedge clk); sys_we = 1'b0;
    endtask
    task automatic wr_per(input logic [2*NP-1:0] c);
        per_we = '1; per_c = c; @(negedge clk); per_we = '0;
    endtask
    task automatic wr_en(input logic e);
        en_we = 1'b1; en_v = e; @(negedge clk); en_we = 1'b0;
    endtask
    task automatic wr_cko(input logic [1:0] c);
        ck_we = 1'b1; ck_c = c; @(negedge clk); ck_we = 1'b0;
    endtask

    task automatic wait_tick(input int idx);
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            if (sig(idx)) return;
        end
    endtask

    task automatic check_period(input int idx, input int exp, input string tag);
        wait_tick(idx);
        for (int k = 0; k < 3; k++) begin
            int n = 0;
            do begin @(negedge clk); n++; end while (!sig(idx) && n < 2000);
            check(tag, n, exp);
        end
    endtask

    task automatic cko_phases(output int hi, output int lo);
        hi = 0; lo = 0;
        for (int i = 0; i < 2000 && cko; i++) @(negedge clk);
        for (int i = 0; i < 2000 && !cko; i++) @(negedge clk);
        while (cko && hi < 2000) begin hi++; @(negedge clk); end
        while (!cko && lo < 2000) begin lo++; @(negedge clk); end
    endtask

    initial begin
        #(CLK_P * 190000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int hi, lo, n, prev;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 sys_tick", sys_tick, 1);
        check("R1 per_tick", per_tick, (1 << NP) - 1);
        check("R1 cko", cko, 0);
        check("R1 err", err, 0);
        // R6 stays low while disabled
        n = 0;
        for (int i = 0; i < 30; i++) begin @(negedge clk); n += cko; end
        check("R6 low before enable", n, 0);
        // R9 default ratio 4
        wr_sys(3'd1);
        wr_en(1'b1);
        repeat (40) @(negedge clk);
        cko_phases(hi, lo);
        check("R9 default high", hi, 4);
        check("R9 default low", lo, 4);
        // R6 disable drives low
        wr_en(1'b0);
        @(negedge clk);
        n = 0;
        for (int i = 0; i < 40; i++) begin n += cko; @(negedge clk); end
        check("R6 low after disable", n, 0);
        // R2 / R3 directed
        wr_sys(3'd4); check_period(0, 16, "R2 code4");
        wr_sys(3'd6); check_period(0, 16, "R3 code6");
        wr_sys(3'd7); check_period(0, 16, "R3 code7");
        // R5 period in progress not shortened
        wr_sys(3'd3);
        repeat (40) @(negedge clk);
        wait_tick(0);
        @(negedge clk);
        wr_sys(3'd0);
        n = 2;
        while (!sys_tick && n < 100) begin @(negedge clk); n++; end
        check("R5 old period kept", n, 8);
        @(negedge clk);
        check("R5 new period", sys_tick, 1);
        // R10 configuration error
        wr_cko(2'd1); wr_en(1'b1);
        check("R10 err set", err, 1);
        wr_cko(2'd2); check("R10 err clear ratio4", err, 0);
        wr_cko(2'd0); check("R10 err ratio1", err, 1);
        wr_sys(3'd1); check("R10 err clear slow", err, 0);
        // R8 ratio 1 follows tick delayed
        repeat (60) @(negedge clk);
        n = 0;
        for (int i = 0; i < 16; i++) begin
            prev = sys_tick; @(negedge clk);
            if (cko != prev) n++;
        end
        check("R8 ratio1 mismatches", n, 0);
        // R11 change applied after high phase
        wr_sys(3'd0); wr_cko(2'd3);
        repeat (60) @(negedge clk);
        for (int i = 0; i < 100 && cko; i++) @(negedge clk);
        for (int i = 0; i < 100 && !cko; i++) @(negedge clk);
        ck_we = 1'b1; ck_c = 2'd1;
        hi = 0;
        while (cko && hi < 100) begin hi++; @(negedge clk); ck_we = 1'b0; end
        lo = 0;
        while (!cko && lo < 100) begin lo++; @(negedge clk); end
        check("R11 old high kept", hi, 4);
        check("R11 new low", lo, 1);
        // random configurations: R2 R3 R4 R7 R10
        for (int it = 0; it < 10; it++) begin
            int sc = $urandom_range(7);
            int cc = $urandom_range(3, 1);
            logic [2*NP-1:0] pc = (2*NP)'($urandom);
            int sp = sys_period(sc);
            wr_sys(3'(sc)); wr_per(pc); wr_cko(2'(cc));
            check("R10 random err", err, (sc == 0 && cc < 2) ? 1 : 0);
            repeat (400) @(negedge clk);
            check_period(0, sp, sc > 4 ? "R3 random sys" : "R2 random sys");
            for (int g = 0; g < NP; g++)
                check_period(g + 1, sp << int'(pc[2*g +: 2]), "R4 random per");
            cko_phases(hi, lo);
            check("R7 random high", hi, sp * (1 << (cc - 1)));
            check("R7 random low", lo, sp * (1 << (cc - 1)));
        end
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule